// File: doc/BRIEF.md
# Flash status register and write-protection controller

This block keeps the two 8-bit status registers of a serial NOR flash and decides whether each command that writes them, or that programs or erases the array, may go ahead. The inputs are command strobes that have already been decoded: an opcode, a count of the data bytes that followed it, up to two data bytes and a 20-bit address. The block also takes the write-protect pin and a pulse that stands for a power-down/power-up cycle.

The block keeps a nonvolatile copy and a visible copy of each register. It models the self-timed cycles of status writes, programs and erases with one counter. During such a cycle the busy flag is high, and the write enable latch drops when the cycle ends. An erase can be suspended and resumed. The block-protect, top/bottom, sector-granularity and complement fields are decoded into a protected address region. A separate check port reports whether any byte address lies outside that region. Read opcodes choose which register appears on the read data output.

Top module: `flash_status_ctrl`

## Requirements
- R1: After reset both registers read 0x00, the read output shows the low register, and every address on the check port is reported writable.
- R2: Opcode 06h sets the write enable latch (low bit 1) and 04h clears it. Neither has an effect while the busy flag (low bit 0) is high.
- R3: A status write (01h) that is accepted with the latch set raises the busy flag for exactly STATUS_CYC cycles. The visible bits do not change until the end of that cycle. The new values then appear and the latch clears.
- R4: Data byte 0 writes low bits 7:2 and byte 1 (cmd_data[15:8]) writes high bits 6, 1 and 0. Low bits 1:0, high bit 2 (reserved) and high bit 7 (suspend) are never written. A write with one byte forces CMP (high bit 6), QE (high bit 1) and SRP1 (high bit 0) to 0. A byte count other than 1 or 2 rejects the write.
- R5: A status write with the latch clear, and with no volatile enable pending, changes nothing.
- R6: Let SRP1 = high bit 0 and SRP0 = low bit 7. With SRP1:SRP0 = 00 the register is writable. With 01 it is locked while wp_n is low and writable while wp_n is high. With 10 it is locked. With 11 it is locked, and a power cycle keeps it locked.
- R7: The lock bits (high bits 5:3) can only be set. A write of 0 leaves them at 1, a volatile write never changes them, and they survive a power cycle.
- R8: Opcode 50h does not set the latch. The next command only, if it is 01h, updates the visible registers on the next cycle with no busy cycle. A power cycle restores the nonvolatile values.
- R9: A power cycle clears the latch, the suspend flag and any pending volatile enable, and it stops a running cycle. If the stored SRP1:SRP0 is 10 it becomes 00.
- R10: With CMP=0 and SEC (low bit 6) = 0, BP = low bits 4:2 equal to 1 to 4 protects the top 1/16, 1/8, 1/4 or 1/2 of the array. When TB (low bit 5) is 1 it protects the same amount at the bottom instead. BP=0 protects nothing and BP of 5 to 7 protects everything.
- R11: With SEC=1, BP of 1 to 4 protects 4, 8, 16 or 32 KB at the top, or at the bottom when TB=1. CMP=1 inverts the protected set.
- R12: Program 02h (256 B page), erase 20h (4 KB), 52h (32 KB), D8h (64 KB) and 60h/C7h (whole array) start only when the latch is set, no cycle is running and the unit touches no protected byte. When accepted, the busy flag is high for ARRAY_CYC cycles and the latch then clears.
- R13: Opcode 75h during an array cycle sets the suspend flag (high bit 7), drops the busy flag and freezes the count. Opcode 7Ah clears the flag and the remaining cycles then run.
- R14: Opcode 05h selects the low register and 35h the high register on rd_data. The output keeps following the live register, even while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 8 | Opcode |
| cmd_nbytes | input | 2 | Number of whole data bytes received after the opcode |
| cmd_data | input | 16 | Data byte 0 in [7:0], byte 1 in [15:8] |
| cmd_addr | input | ADDR_W | Target address of a program or erase |
| wp_n | input | 1 | Write-protect pin, active low |
| pwr_cycle | input | 1 | Pulse marking a power-down/power-up cycle |
| chk_addr | input | ADDR_W | Address to test against the protection map |
| chk_ok | output | 1 | High when chk_addr is not protected |
| sr_lo | output | 8 | Live low status register |
| sr_hi | output | 8 | Live high status register |
| rd_data | output | 8 | Register chosen by the last read opcode |

## Verification
The bench builds the block with STATUS_CYC=4 and ARRAY_CYC=6. These short cycles let it count the busy window to the exact edge and still hold a suspend open for many cycles. The address width stays at 20, so the bench sweeps all 64 settings of SEC, TB, CMP and BP. For each setting it tests both ends of every 2 KB slice against a region computed from fractions of the array size, which reaches every region boundary in both directions.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDLO  = 8'h05;
    localparam logic [7:0] OP_RDHI  = 8'h35;
    localparam logic [7:0] OP_VWREN = 8'h50;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_PP    = 8'h02;
    localparam logic [7:0] OP_SE    = 8'h20;
    localparam logic [7:0] OP_BE32  = 8'h52;
    localparam logic [7:0] OP_BE64  = 8'hD8;
    localparam logic [7:0] OP_CE1   = 8'h60;
    localparam logic [7:0] OP_CE2   = 8'hC7;
    localparam logic [7:0] OP_SUSP  = 8'h75;
    localparam logic [7:0] OP_RESM  = 8'h7A;

    localparam int PAGE_W     = 8;
    localparam int HALF_BLK_W = 15;
    localparam int BLK_W      = 16;

    // Stored bits: lo[7:2] = SRP0,SEC,TB,BP2..BP0; hi[6:0] = CMP,LB3..LB1,rsv,QE,SRP1
    typedef struct packed {
        logic [7:2] lo;
        logic [6:0] hi;
        logic [7:2] nv_lo;
        logic [6:0] nv_hi;
        logic [7:2] pend_lo;
        logic [6:0] pend_hi;
        logic       pend_sr;
        logic       wel;
        logic       sus;
        logic       vol_en;
        logic       rd_hi;
    } sr_state_t;

endpackage

// File: rtl/flash_prot_map.sv
module flash_prot_map #(
    parameter int ADDR_W = 20,
    parameter int SECT_W = 12
) (
    input  logic              sec,
    input  logic              tb,
    input  logic              cmp,
    input  logic [2:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              prot
);
    localparam int LOG_W = $clog2(ADDR_W + 1);

    logic [LOG_W-1:0]  span_w;
    logic [ADDR_W-1:0] hi_mask;
    logic              in_rng;
    logic              region;

    always_comb begin
        span_w  = sec ? LOG_W'(SECT_W - 1) + LOG_W'(bp)
                      : LOG_W'(ADDR_W - 5) + LOG_W'(bp);
        hi_mask = {ADDR_W{1'b1}} << span_w;
        in_rng  = tb ? ((addr & hi_mask) == '0)
                     : ((addr & hi_mask) == hi_mask);
        if (bp == 3'd0)       region = 1'b0;
        else if (bp >= 3'd5)  region = 1'b1;
        else                  region = in_rng;
        prot = region ^ cmp;
    end
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    input  logic             hold,
    input  logic             abort,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign busy = (cnt_q != '0);
    assign done = busy && !hold && (cnt_q == CNT_W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (abort)              cnt_d = '0;
        else if (start)         cnt_d = len;
        else if (busy && !hold) cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TIMER_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !busy); // R3
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
    import flash_sr_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int SECT_W     = 12,
    parameter int STATUS_CYC = 8,
    parameter int ARRAY_CYC  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [1:0]        cmd_nbytes,
    input  logic [15:0]       cmd_data,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              wp_n,
    input  logic              pwr_cycle,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              chk_ok,
    output logic [7:0]        sr_lo,
    output logic [7:0]        sr_hi,
    output logic [7:0]        rd_data
);
    localparam int MAX_CYC = (STATUS_CYC > ARRAY_CYC) ? STATUS_CYC : ARRAY_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int LOG_W   = $clog2(ADDR_W + 1);

    sr_state_t st_d, st_q;

    logic             tmr_start, tmr_abort, tmr_busy, tmr_done;
    logic [CNT_W-1:0] tmr_len;
    logic             wip;

    logic              is_array;
    logic [LOG_W-1:0]  unit_w;
    logic [ADDR_W-1:0] unit_mask;
    logic [ADDR_W-1:0] pm_addr [3];
    logic [2:0]        pm_prot;
    logic              unit_prot;

    logic       sr_locked, len_ok;
    logic [7:2] wr_lo;
    logic [6:0] wr_hi, vol_hi;
    logic       unused_data;

    assign unused_data = ^{cmd_data[15], cmd_data[10], cmd_data[1:0]};
    assign wip = tmr_busy && !st_q.sus;

    // Size of the unit a program or erase touches
    always_comb begin
        is_array = 1'b1;
        unit_w   = '0;
        case (cmd_op)
            OP_PP:          unit_w = LOG_W'(PAGE_W);
            OP_SE:          unit_w = LOG_W'(SECT_W);
            OP_BE32:        unit_w = LOG_W'(HALF_BLK_W);
            OP_BE64:        unit_w = LOG_W'(BLK_W);
            OP_CE1, OP_CE2: unit_w = LOG_W'(ADDR_W);
            default:        is_array = 1'b0;
        endcase
        unit_mask = {ADDR_W{1'b1}} << unit_w;
    end

    assign pm_addr[0] = chk_addr;
    assign pm_addr[1] = cmd_addr & unit_mask;
    assign pm_addr[2] = cmd_addr | ~unit_mask;

    // One decoder per probe: check port, first and last byte of the unit
    for (genvar g = 0; g < 3; g++) begin : g_probe
        flash_prot_map #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) i_map (
            .sec  (st_q.lo[6]),
            .tb   (st_q.lo[5]),
            .cmp  (st_q.hi[6]),
            .bp   (st_q.lo[4:2]),
            .addr (pm_addr[g]),
            .prot (pm_prot[g])
        );
    end

    assign chk_ok    = !pm_prot[0];
    assign unit_prot = pm_prot[1] | pm_prot[2];

    flash_busy_timer #(.CNT_W(CNT_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .len   (tmr_len),
        .hold  (st_q.sus),
        .abort (tmr_abort),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    // Lock matrix and merged write values
    always_comb begin
        sr_locked = st_q.hi[0] || (st_q.lo[7] && !wp_n);
        len_ok    = (cmd_nbytes == 2'd1) || (cmd_nbytes == 2'd2);
        wr_lo     = cmd_data[7:2];
        if (cmd_nbytes == 2'd2)
            wr_hi = {cmd_data[14], st_q.hi[5:3] | cmd_data[13:11], 1'b0, cmd_data[9:8]};
        else
            wr_hi = {1'b0, st_q.hi[5:3], 3'b000};
        vol_hi = {wr_hi[6], st_q.hi[5:3], wr_hi[2:0]};
    end

    always_comb begin
        st_d      = st_q;
        tmr_start = 1'b0;
        tmr_len   = CNT_W'(ARRAY_CYC);
        tmr_abort = 1'b0;

        if (cmd_valid) begin
            st_d.vol_en = 1'b0;
            case (cmd_op)
                OP_RDLO:  st_d.rd_hi = 1'b0;
                OP_RDHI:  st_d.rd_hi = 1'b1;
                OP_WREN:  if (!wip) st_d.wel = 1'b1;
                OP_WRDI:  if (!wip) st_d.wel = 1'b0;
                OP_VWREN: if (!wip) st_d.vol_en = 1'b1;
                OP_WRSR: begin
                    if (!tmr_busy && len_ok && !sr_locked) begin
                        if (st_q.vol_en) begin
                            st_d.lo = wr_lo;
                            st_d.hi = vol_hi;
                        end else if (st_q.wel) begin
                            tmr_start    = 1'b1;
                            tmr_len      = CNT_W'(STATUS_CYC);
                            st_d.pend_sr = 1'b1;
                            st_d.pend_lo = wr_lo;
                            st_d.pend_hi = wr_hi;
                        end
                    end
                end
                OP_SUSP:  if (wip && !st_q.pend_sr) st_d.sus = 1'b1;
                OP_RESM:  if (st_q.sus) st_d.sus = 1'b0;
                default: begin
                    if (is_array && !tmr_busy && st_q.wel && !unit_prot) begin
                        tmr_start    = 1'b1;
                        st_d.pend_sr = 1'b0;
                    end
                end
            endcase
        end

        if (tmr_done) begin
            if (st_q.pend_sr) begin
                st_d.lo    = st_q.pend_lo;
                st_d.hi    = st_q.pend_hi;
                st_d.nv_lo = st_q.pend_lo;
                st_d.nv_hi = st_q.pend_hi;
            end
            st_d.wel = 1'b0;
        end

        if (pwr_cycle) begin
            st_d.lo     = st_q.nv_lo;
            st_d.hi     = st_q.nv_hi;
            st_d.wel    = 1'b0;
            st_d.sus    = 1'b0;
            st_d.vol_en = 1'b0;
            st_d.rd_hi  = 1'b0;
            tmr_abort   = 1'b1;
            if (st_q.nv_hi[0] && !st_q.nv_lo[7]) begin
                st_d.nv_hi[0] = 1'b0;
                st_d.hi[0]    = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sr_lo   = {st_q.lo, st_q.wel, wip};
    assign sr_hi   = {st_q.sus, st_q.hi};
    assign rd_data = st_q.rd_hi ? sr_hi : sr_lo;

    AST_LB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sr_hi[5:3] & $past(sr_hi[5:3])) == $past(sr_hi[5:3]))); // R7
    AST_SUS_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sr_hi[7] |-> tmr_busy); // R13
    AST_WEL_DROP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_done && !pwr_cycle) |=> !sr_lo[1]); // R12
    AST_SRP_PERMANENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_hi[0] && sr_lo[7]) |=> (sr_hi[0] && sr_lo[7])); // R6
    AST_REG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_busy && !tmr_done && !pwr_cycle) |=> $stable(sr_lo[7:2])); // R3
endmodule

// File: tb/test_flash_status_ctrl.sv
module test_flash_status_ctrl;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 20;
    localparam int SCYC   = 4;
    localparam int ACYC   = 6;
    localparam int SIZE   = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [7:0]        cmd_op = '0;
    logic [1:0]        cmd_nbytes = '0;
    logic [15:0]       cmd_data = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic              wp_n = 1'b1;
    logic              pwr_cycle = 1'b0;
    logic [ADDR_W-1:0] chk_addr = '0;
    logic              chk_ok;
    logic [7:0]        sr_lo, sr_hi, rd_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    flash_status_ctrl #(.ADDR_W(ADDR_W), .SECT_W(12), .STATUS_CYC(SCYC), .ARRAY_CYC(ACYC))
    i_flash_status_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_nbytes(cmd_nbytes), .cmd_data(cmd_data), .cmd_addr(cmd_addr),
        .wp_n(wp_n), .pwr_cycle(pwr_cycle), .chk_addr(chk_addr), .chk_ok(chk_ok),
        .sr_lo(sr_lo), .sr_hi(sr_hi), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] op, input logic [1:0] n = 2'd0,
                        input logic [15:0] d = 16'h0, input logic [19:0] a = 20'h0);
        cmd_valid = 1'b1; cmd_op = op; cmd_nbytes = n; cmd_data = d; cmd_addr = a;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic power;
        pwr_cycle = 1'b1;
        @(negedge clk);
        pwr_cycle = 1'b0;
    endtask

    function automatic bit exp_prot(input int sec, input int tb, input int cmp,
                                    input int bp, input int a);
        int len;
        bit r;
        if (bp == 0)      len = 0;
        else if (bp >= 5) len = SIZE;
        else if (sec != 0) len = 4096 << (bp - 1);
        else              len = (SIZE / 16) << (bp - 1);
        r = (tb != 0) ? (a < len) : (a >= SIZE - len);
        return r ^ bit'(cmp);
    endfunction

    initial begin
        #(CLK_P * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 sr_lo", sr_lo, 8'h00);
        check("R1 sr_hi", sr_hi, 8'h00);
        check("R1 rd_data", rd_data, 8'h00);
        chk_addr = 20'hFFFFF; #1;
        check("R1 chk_ok", chk_ok, 1'b1);

        // R2 latch set and clear
        send(8'h06); check("R2 wel set", sr_lo, 8'h02);
        send(8'h04); check("R2 wel clear", sr_lo, 8'h00);

        // R5 write without latch
        send(8'h01, 2'd2, 16'h401C); tick(SCYC + 1);
        check("R5 lo", sr_lo, 8'h00); check("R5 hi", sr_hi, 8'h00);

        // R3 R4 two-byte nonvolatile write
        send(8'h06);
        send(8'h01, 2'd2, 16'hC61F);
        check("R3 busy first", sr_lo, 8'h03);
        tick(SCYC - 1); check("R3 busy last", sr_lo, 8'h03);
        tick(1);
        check("R3 R4 lo applied", sr_lo, 8'h1C);
        check("R4 hi masked", sr_hi, 8'h42);

        // R4 one-byte write clears CMP QE SRP1
        send(8'h06); send(8'h01, 2'd1, 16'h0004); tick(SCYC);
        check("R4 short lo", sr_lo, 8'h04); check("R4 short hi", sr_hi, 8'h00);

        // R4 bad byte count rejected
        send(8'h06); send(8'h01, 2'd3, 16'h0010); tick(SCYC + 1);
        check("R4 bad count", sr_lo, 8'h06);
        send(8'h04);

        // R14 register select
        send(8'h06); send(8'h35); check("R14 hi sel", rd_data, 8'h00);
        send(8'h05); check("R14 lo sel", rd_data, 8'h06);
        tick(3); check("R14 repeat", rd_data, 8'h06);
        send(8'h04);

        // R8 volatile path
        send(8'h50); send(8'h01, 2'd2, 16'h4010);
        check("R8 vol lo", sr_lo, 8'h10); check("R8 vol hi", sr_hi, 8'h40);
        send(8'h01, 2'd2, 16'h0000); tick(SCYC + 1);
        check("R8 one shot", sr_lo, 8'h10);
        power();
        check("R8 restore lo", sr_lo, 8'h04); check("R8 restore hi", sr_hi, 8'h00);
        send(8'h50); send(8'h04); send(8'h01, 2'd2, 16'h0000); tick(SCYC + 1);
        check("R8 consumed", sr_lo, 8'h04);

        // R10 R11 protection sweep over all field settings
        for (int cfg = 0; cfg < 64; cfg++) begin
            int bp, tb, sec, cmp;
            bp  = cfg & 7;
            tb  = (cfg >> 3) & 1;
            sec = (cfg >> 4) & 1;
            cmp = (cfg >> 5) & 1;
            send(8'h50);
            send(8'h01, 2'd2, {1'b0, cmp[0], 6'b0, 1'b0, sec[0], tb[0], bp[2:0], 2'b00});
            for (int i = 0; i < 1024; i++) begin
                int a;
                a = (i >> 1) * 2048 + (((i & 1) != 0) ? 2047 : 0);
                chk_addr = a[ADDR_W-1:0];
                #1;
                if (sec != 0 || cmp != 0)
                    check("R11 map", chk_ok, !exp_prot(sec, tb, cmp, bp, a));
                else
                    check("R10 map", chk_ok, !exp_prot(sec, tb, cmp, bp, a));
            end
            @(negedge clk);
        end
        power();
        check("R10 back to stored", sr_lo, 8'h04);

        // R12 array operations with top 64 KB protected
        send(8'h06);
        send(8'h02, 2'd0, 16'h0, 20'hF0010); tick(ACYC + 1);
        check("R12 protected page", sr_lo, 8'h06);
        send(8'h60); tick(ACYC + 1);
        check("R12 chip erase blocked", sr_lo, 8'h06);
        send(8'hD8, 2'd0, 16'h0, 20'hE1234);
        check("R12 erase start", sr_lo, 8'h07);
        tick(ACYC - 1); check("R12 erase last", sr_lo, 8'h07);
        tick(1); check("R12 erase done", sr_lo, 8'h04);
        send(8'h02, 2'd0, 16'h0, 20'h00100); tick(1);
        check("R12 needs latch", sr_lo, 8'h04);

        // R13 suspend and resume
        send(8'h06); send(8'h20, 2'd0, 16'h0, 20'h00000);
        tick(1); send(8'h75);
        check("R13 suspended lo", sr_lo, 8'h06); check("R13 suspended hi", sr_hi, 8'h80);
        tick(10); check("R13 frozen", sr_lo, 8'h06);
        send(8'h7A);
        check("R13 resumed", sr_lo, 8'h07); check("R13 flag clear", sr_hi, 8'h00);
        tick(3); check("R13 remaining", sr_lo, 8'h07);
        tick(1); check("R13 ended", sr_lo, 8'h04);
        send(8'h06); send(8'h20); send(8'h75); power();
        check("R9 sus cleared", sr_hi, 8'h00);
        tick(ACYC + 1); check("R9 cycle stopped", sr_lo, 8'h04);

        // R7 one-time lock bits
        send(8'h06); send(8'h01, 2'd2, 16'h0804); tick(SCYC);
        check("R7 set", sr_hi, 8'h08);
        send(8'h06); send(8'h01, 2'd2, 16'h0004); tick(SCYC);
        check("R7 stays", sr_hi, 8'h08);
        power(); check("R7 power", sr_hi, 8'h08);

        // R6 R9 lock matrix
        send(8'h06); send(8'h01, 2'd1, 16'h0084); tick(SCYC);
        check("R6 srp01 set", sr_lo, 8'h84); check("R4 keeps LB", sr_hi, 8'h08);
        wp_n = 1'b0;
        send(8'h06); send(8'h01, 2'd1, 16'h0080); tick(SCYC + 1);
        check("R6 pin locks", sr_lo, 8'h86);
        wp_n = 1'b1;
        send(8'h01, 2'd1, 16'h0080); tick(SCYC);
        check("R6 pin high writes", sr_lo, 8'h80);
        send(8'h06); send(8'h01, 2'd2, 16'h0900); tick(SCYC);
        check("R6 srp10 set", sr_hi, 8'h09);
        send(8'h06); send(8'h01, 2'd2, 16'h0804); tick(SCYC + 1);
        check("R6 srp10 locked", sr_lo, 8'h02);
        power();
        check("R9 srp back to 00", sr_hi, 8'h08); check("R9 wel cleared", sr_lo, 8'h00);
        send(8'h06); send(8'h01, 2'd2, 16'h0980); tick(SCYC);
        check("R6 srp11 set", sr_hi, 8'h09);
        power();
        check("R6 srp11 after power", sr_hi, 8'h09);
        send(8'h06); send(8'h01, 2'd2, 16'h0800); tick(SCYC + 1);
        check("R6 srp11 locked", sr_lo, 8'h82);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule